// File: doc/BRIEF.md
# Decimal Signed-Digit Partial Product Generator

This block produces every partial product of an N×N-digit decimal multiplication in one pass of logic. Each BCD digit of the multiplier is recoded into a signed digit between -5 and +5. That digit selects one of six multiples of the multiplicand (zero to five times) and negates it when the digit is negative. The multiples are built once and shared by all rows. They are held in a redundant excess-3 digit code: every 4-bit code stores the digit value plus 3, and a code may range over 0 to 15, so a digit value may lie between -3 and 12. Because the redundancy absorbs local overflow, each digit of a multiple depends only on two neighbouring multiplicand digits, and no carry ripples along the row.

The code is self-complementing. Inverting all bits of a code c gives 15 - c, which stands for 9 minus the original value. A negative row is therefore the plain bitwise complement of the positive multiple, together with a row flag. The reduction tree that follows uses that flag for two things: a +1 at the row's least significant digit, and a -10^(N+1) sign weight at the row's own offset. The tree strips the excess-3 bias of all rows together by subtracting one constant, C = 3·R·R, where R is the repunit of N+1 ones. With this constant the sum becomes plain overloaded BCD. N+1 rows of N+1 digits come out, and row i carries weight 10^i. An optional output register, selected by a parameter, holds rows and flags.

Top module: `ppg_top`

## Requirements
- R1: Recoding. Let t_i = 1 when multiplier digit y_i ≥ 5, with t_-1 = 0. The signed digit of row i (i < N) is s_i = y_i − 10·t_i + t_(i−1), and pp_neg[i] is 1 exactly when s_i < 0. Multiplier BCD digit i sits at y_bcd[4i+3:4i].
- R2: Row digit j of row i sits at pp_digits[4(i·(N+1)+j)+3 : 4(i·(N+1)+j)] and stores its value plus 3. In a positive row every code lies in 3..15. In a negative row every code lies in 0..12.
- R3: Decode a row as D = Σ_j (code_j − 3)·10^j. A negative row satisfies D + 1 − 10^(N+1) = s_i·X, and a positive row satisfies D = s_i·X, where X is the multiplicand value.
- R4: A change to multiplicand digit j alters no digit of any row outside positions j and j+1 (carry-free generation).
- R5: Row N equals t_(N−1)·X and is never flagged negative.
- R6: Σ_i Σ_j code_ij·10^(i+j) − C + Σ_(i: pp_neg[i]) (10^i − 10^(N+1+i)) equals X·Y, where C = 3·R·R and R = (10^(N+1) − 1)/9.
- R7: For a zero multiplicand, every positive row is all codes 3 and every negative row is all codes 12.
- R8: With OUT_REG = 1, outputs change only one clock after the inputs, and while rst_n is low pp_digits and pp_neg are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| x_bcd | input | 4·N | Multiplicand, BCD, digit i at bits 4i+3:4i |
| y_bcd | input | 4·N | Multiplier, BCD, digit i at bits 4i+3:4i |
| pp_digits | output | 4·(N+1)·(N+1) | Partial product rows in excess-3 redundant code, row-major |
| pp_neg | output | N+1 | Per-row negation flag (sign and +1 correction) |

## Verification
The bench builds the block with N = 16 and OUT_REG = 1. This gives seventeen rows of seventeen digits and products of up to thirty-two digits, which the bench holds exactly in 256-bit integer arithmetic. The registered variant brings the reset clearing and the one-cycle output latency into reach. The full digit width lets the bench move a single multiplicand digit at every position, including the top one, which feeds the extra row digit.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  localparam int unsigned XS3_OFS = 3;

  typedef struct packed {
    logic [2:0] hi;  // transfer to next digit (0..4)
    logic [3:0] lo;  // local units digit (0..9)
  } split_t;

  // Split k*d (k in 1..5, d in 0..9) into tens and units.
  function automatic split_t split_mul(input logic [2:0] k, input logic [3:0] d);
    logic [5:0] prod;
    split_t     res;
    prod   = 6'(k) * 6'(d);
    res.hi = 3'(prod / 6'd10);
    res.lo = 4'(prod - 6'(res.hi) * 6'd10);
    return res;
  endfunction

endpackage

// File: rtl/ppg_recoder.sv
module ppg_recoder #(
  parameter int N = 16
) (
  input  logic [4*N-1:0]     y_bcd,
  output logic [3*(N+1)-1:0] sel_mag,
  output logic [N:0]         sel_neg
);

  logic [N:0] xfer;  // xfer[i+1] is the transfer out of digit i

  assign xfer[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_dig
    logic [3:0] yd;
    logic [2:0] hi_mag;
    logic [2:0] lo_mag;
    logic [2:0] mag;

    assign yd        = y_bcd[4*i +: 4];
    assign xfer[i+1] = (yd >= 4'd5);
    assign hi_mag    = 3'(4'd10 - yd) - {2'b00, xfer[i]};
    assign lo_mag    = 3'(yd) + {2'b00, xfer[i]};

    always_comb begin
      if (xfer[i+1]) begin
        mag = hi_mag;
      end else begin
        mag = lo_mag;
      end
    end

    assign sel_mag[3*i +: 3] = mag;
    assign sel_neg[i]        = xfer[i+1] && (mag != 3'd0);
  end

  assign sel_mag[3*N +: 3] = {2'b00, xfer[N]};
  assign sel_neg[N]        = 1'b0;

endmodule

// File: rtl/ppg_multiples.sv
module ppg_multiples
  import ppg_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [4*N-1:0]               x_bcd,
  output logic [5:1][4*(N+1)-1:0]      mult
);

  for (genvar k = 1; k <= 5; k++) begin : g_k
    split_t sp [N];

    for (genvar j = 0; j < N; j++) begin : g_split
      assign sp[j] = split_mul(3'(k), x_bcd[4*j +: 4]);
    end

    for (genvar j = 0; j <= N; j++) begin : g_dig
      logic [3:0] lo_part;
      logic [3:0] hi_part;

      if (j < N) begin : g_lo
        assign lo_part = sp[j].lo;
      end else begin : g_lo0
        assign lo_part = 4'd0;
      end

      if (j > 0) begin : g_hi
        assign hi_part = {1'b0, sp[j-1].hi};
      end else begin : g_hi0
        assign hi_part = 4'd0;
      end

      assign mult[k][4*j +: 4] = lo_part + hi_part + 4'(XS3_OFS);
    end
  end

endmodule

// File: rtl/ppg_row_sel.sv
module ppg_row_sel #(
  parameter int W = 17
) (
  input  logic [2:0]             mag,
  input  logic                   neg,
  input  logic [5:1][4*W-1:0]    mult,
  output logic [4*W-1:0]         row
);

  localparam logic [4*W-1:0] ZERO_ROW = {W{4'd3}};

  logic [4*W-1:0] pos_row;

  always_comb begin
    case (mag)
      3'd1:    pos_row = mult[1];
      3'd2:    pos_row = mult[2];
      3'd3:    pos_row = mult[3];
      3'd4:    pos_row = mult[4];
      3'd5:    pos_row = mult[5];
      default: pos_row = ZERO_ROW;
    endcase
  end

  assign row = neg ? ~pos_row : pos_row;

endmodule

// File: rtl/ppg_top.sv
module ppg_top #(
  parameter int N       = 16,
  parameter int OUT_REG = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [4*N-1:0]             x_bcd,
  input  logic [4*N-1:0]             y_bcd,
  output logic [4*(N+1)*(N+1)-1:0]   pp_digits,
  output logic [N:0]                 pp_neg
);

  localparam int W    = N + 1;
  localparam int ROWB = 4 * W;

  logic [3*W-1:0]           sel_mag;
  logic [W-1:0]             sel_neg;
  logic [5:1][ROWB-1:0]     mult;
  logic [ROWB*W-1:0]        pp_d;

  ppg_recoder #(.N(N)) u_rec (
    .y_bcd   (y_bcd),
    .sel_mag (sel_mag),
    .sel_neg (sel_neg)
  );

  ppg_multiples #(.N(N)) u_mul (
    .x_bcd (x_bcd),
    .mult  (mult)
  );

  for (genvar r = 0; r < W; r++) begin : g_row
    ppg_row_sel #(.W(W)) u_sel (
      .mag  (sel_mag[3*r +: 3]),
      .neg  (sel_neg[r]),
      .mult (mult),
      .row  (pp_d[ROWB*r +: ROWB])
    );
  end

  if (OUT_REG != 0) begin : g_reg
    logic [ROWB*W-1:0] pp_q;
    logic [W-1:0]      neg_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pp_q  <= '0;
        neg_q <= '0;
      end else begin
        pp_q  <= pp_d;
        neg_q <= sel_neg;
      end
    end

    assign pp_digits = pp_q;
    assign pp_neg    = neg_q;
  end else begin : g_comb
    assign pp_digits = pp_d;
    assign pp_neg    = sel_neg;
  end

endmodule

// File: rtl/ppg_checker.sv
module ppg_checker #(
  parameter int N       = 16,
  parameter int OUT_REG = 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [4*N-1:0]             x_bcd,
  input logic [4*N-1:0]             y_bcd,
  input logic [4*(N+1)*(N+1)-1:0]   pp_digits,
  input logic [N:0]                 pp_neg
);

  localparam int W    = N + 1;
  localparam int ROWB = 4 * W;

  function automatic logic codes_min3(input logic [ROWB-1:0] rv);
    logic ok;
    ok = 1'b1;
    for (int j = 0; j < W; j++) if (rv[4*j +: 4] < 4'd3) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic codes_max12(input logic [ROWB-1:0] rv);
    logic ok;
    ok = 1'b1;
    for (int j = 0; j < W; j++) if (rv[4*j +: 4] > 4'd12) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic codes_all(input logic [ROWB-1:0] rv, input logic [3:0] c);
    logic ok;
    ok = 1'b1;
    for (int j = 0; j < W; j++) if (rv[4*j +: 4] != c) ok = 1'b0;
    return ok;
  endfunction

  logic [4*N-1:0] x_q;
  logic [4*N-1:0] y_q;
  logic           v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      v_q <= 1'b0;
    end else begin
      x_q <= x_bcd;
      y_q <= y_bcd;
      v_q <= 1'b1;
    end
  end

  logic [4*N-1:0] x_ref;
  logic [4*N-1:0] y_ref;
  logic           ok_ref;

  if (OUT_REG != 0) begin : g_lat
    assign x_ref  = x_q;
    assign y_ref  = y_q;
    assign ok_ref = v_q;
  end else begin : g_now
    assign x_ref  = x_bcd;
    assign y_ref  = y_bcd;
    assign ok_ref = 1'b1;
  end

  // R5: the extra row is never negative
  assert_top_row_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ok_ref |-> !pp_neg[N]);

  // R1: lowest row sign follows the lowest multiplier digit
  assert_row0_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ok_ref |-> (pp_neg[0] == (y_ref[3:0] >= 4'd5)));

  // R1: zero multiplier gives no negative rows
  assert_zero_y_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_ref && y_ref == '0) |-> (pp_neg == '0));

  for (genvar r = 0; r < W; r++) begin : g_row
    logic [ROWB-1:0] rv;
    assign rv = pp_digits[ROWB*r +: ROWB];

    assert_code_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_ref && !pp_neg[r]) |-> codes_min3(rv));

    assert_code_ceil_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_ref && pp_neg[r]) |-> codes_max12(rv));

    assert_zero_x_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_ref && x_ref == '0) |-> codes_all(rv, pp_neg[r] ? 4'd12 : 4'd3));
  end

endmodule

bind ppg_top ppg_checker #(.N(N), .OUT_REG(OUT_REG)) u_ppg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .x_bcd     (x_bcd),
  .y_bcd     (y_bcd),
  .pp_digits (pp_digits),
  .pp_neg    (pp_neg)
);

// File: tb/test_ppg_top.sv
`timescale 1ns/1ps
module test_ppg_top;

  localparam int N = 16;
  localparam int W = N + 1;

  typedef logic signed [255:0] big_t;

  logic                 clk;
  logic                 rst_n;
  logic [4*N-1:0]       x;
  logic [4*N-1:0]       y;
  logic [4*W*W-1:0]     pp;
  logic [W-1:0]         neg;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  ppg_top #(.N(N), .OUT_REG(1)) i_ppg_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .x_bcd     (x),
    .y_bcd     (y),
    .pp_digits (pp),
    .pp_neg    (neg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic big_t p10(input int k);
    big_t r;
    r = 1;
    for (int i = 0; i < k; i++) r = r * 10;
    return r;
  endfunction

  function automatic big_t bcd_val(input logic [4*N-1:0] v);
    big_t r;
    r = 0;
    for (int i = N - 1; i >= 0; i--) r = r * 10 + big_t'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic int sdig(input logic [4*N-1:0] yv, input int i);
    int tin, tout, d;
    tin = 0;
    for (int k = 0; k < N; k++) begin
      d    = int'(yv[4*k +: 4]);
      tout = (d >= 5) ? 1 : 0;
      if (k == i) return d - 10 * tout + tin;
      tin = tout;
    end
    return tin;
  endfunction

  function automatic logic [4*N-1:0] rand_bcd();
    logic [4*N-1:0] v;
    for (int i = 0; i < N; i++) v[4*i +: 4] = 4'($urandom % 10);
    return v;
  endfunction

  function automatic logic [4*N-1:0] fill_bcd(input logic [3:0] d);
    logic [4*N-1:0] v;
    for (int i = 0; i < N; i++) v[4*i +: 4] = d;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input big_t act, input big_t exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [4*N-1:0] xv, input logic [4*N-1:0] yv);
    @(negedge clk);
    x = xv;
    y = yv;
    @(negedge clk);
  endtask

  // Checks rows currently on the outputs against x and y (R1, R2, R3, R5, R6)
  task automatic verify();
    big_t xv, yv, rv, e, total, rep, cst;
    logic [W-1:0] eneg;
    bit   rng_ok;
    int   s, c;
    xv = bcd_val(x);
    yv = bcd_val(y);
    for (int i = 0; i < W; i++) eneg[i] = (sdig(y, i) < 0);
    chk(neg == eneg, "R1 row signs", big_t'(neg), big_t'(eneg));
    total  = 0;
    rng_ok = 1;
    for (int i = 0; i < W; i++) begin
      rv = 0;
      for (int j = 0; j < W; j++) begin
        c = int'(pp[4*(i*W+j) +: 4]);
        rv = rv + (big_t'(c) - 3) * p10(j);
        total = total + big_t'(c) * p10(i + j);
        if (!neg[i] && c < 3) rng_ok = 0;
        if (neg[i] && c > 12) rng_ok = 0;
      end
      if (neg[i]) begin
        rv = rv + 1 - p10(W);
        total = total + p10(i) - p10(W + i);
      end
      s = sdig(y, i);
      e = xv * big_t'((s < 0) ? -s : s);
      if (s < 0) e = -e;
      if (i == N)     chk(rv == e, "R5 extra row value", rv, e);
      else if (s < 0) chk(rv == e, "R3 negated row value", rv, e);
      else            chk(rv == e, "R1 row value", rv, e);
    end
    chk(rng_ok, "R2 code range", big_t'(rng_ok), 1);
    rep = (p10(W) - 1) / 9;
    cst = 3 * rep * rep;
    total = total - cst;
    chk(total == xv * yv, "R6 weighted sum", total, xv * yv);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4*N-1:0] xa, ya, x2;
    logic [4*W*W-1:0] pp_prev;
    logic [3:0] nd;
    int j;
    bit same, ok7;
    logic [3:0] want;
    void'($urandom(32'd1234));

    rst_n = 1'b0;
    x = fill_bcd(4'd7);
    y = fill_bcd(4'd8);
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(pp == '0 && neg == '0, "R8 reset clears outputs", big_t'(neg), 0);
    rst_n = 1'b1;

    // Directed corners
    apply('0, '0);                         verify();
    apply(fill_bcd(4'd9), fill_bcd(4'd9)); verify();
    apply(rand_bcd(), fill_bcd(4'd5));     verify();
    apply(fill_bcd(4'd9), fill_bcd(4'd4)); verify();
    apply(rand_bcd(), fill_bcd(4'd9));     verify();
    begin
      logic [4*N-1:0] pat;
      for (int i = 0; i < N; i++) begin
        case (i % 4)
          0: pat[4*i +: 4] = 4'd0;
          1: pat[4*i +: 4] = 4'd4;
          2: pat[4*i +: 4] = 4'd5;
          default: pat[4*i +: 4] = 4'd9;
        endcase
      end
      apply(pat, pat);               verify();
      apply(rand_bcd(), pat);        verify();
    end

    // R7: zero multiplicand
    apply('0, rand_bcd());
    verify();
    ok7 = 1;
    for (int i = 0; i < W; i++) begin
      want = neg[i] ? 4'd12 : 4'd3;
      for (int k = 0; k < W; k++) if (pp[4*(i*W+k) +: 4] != want) ok7 = 0;
    end
    chk(ok7, "R7 zero multiplicand codes", big_t'(ok7), 1);

    // R8: output holds until the clock edge
    xa = rand_bcd();
    ya = rand_bcd();
    apply(xa, ya);
    pp_prev = pp;
    @(negedge clk);
    x = rand_bcd();
    y = rand_bcd();
    #1;
    chk(pp == pp_prev, "R8 no change before clock edge", 0, 0);
    @(negedge clk);
    verify();

    // R4: carry-free locality
    for (int t = 0; t < 8; t++) begin
      xa = rand_bcd();
      ya = rand_bcd();
      j  = (t == 0) ? N - 1 : (t == 1 ? 0 : int'($urandom % N));
      apply(xa, ya);
      pp_prev = pp;
      nd = 4'((int'(xa[4*j +: 4]) + 1 + int'($urandom % 9)) % 10);
      x2 = xa;
      x2[4*j +: 4] = nd;
      apply(x2, ya);
      same = 1;
      for (int i = 0; i < W; i++)
        for (int k = 0; k < W; k++)
          if (k != j && k != j + 1 && pp[4*(i*W+k) +: 4] != pp_prev[4*(i*W+k) +: 4]) same = 0;
      chk(same, "R4 change stays within two digits", big_t'(same), 1);
    end

    // Random operands
    for (int t = 0; t < 200; t++) begin
      apply(rand_bcd(), rand_bcd());
      verify();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule